// File: doc/BRIEF.md
# Adaptive Hold Decision Unit for a Variable-Latency Multiplier

This block sits next to a bypassing multiplier array and decides, for every multiplication it is shown, whether the product may be captured after a single clock cycle or needs to be held for a second one. It counts the zero bits of one operand. A bypassing array skips adder cells for zero bits, so an operand with many zeros has a short worst-case path. That count is compared against a skip threshold. When the array bypasses by columns the multiplicand is judged. When it bypasses by rows the multiplier operand is judged. A build-time parameter picks between the two.

Two judging slices run side by side, one per threshold. The looser threshold is used while the silicon is fresh. An aging monitor watches the timing-error flag raised by the result registers whenever a one-cycle capture turned out to be wrong. It counts those errors over a fixed window of operations and clears the count at each window boundary. If a single window sees more errors than a set limit, the monitor raises its aged flag. That flag then stays set until reset and switches the selector to the stricter threshold, so fewer operations are granted one cycle. The decision is registered before it leaves the block.

Top module: `adaptive_hold`

## Requirements
- R1: An operation is classed one-cycle (`one_cycle_o` = 1) when the zero-bit count of the judged operand is greater than or equal to the active skip number, and two-cycle (`one_cycle_o` = 0) otherwise.
- R2: With `ROW_MODE` = 0 the judged operand is `mcand_i`; with `ROW_MODE` = 1 it is `mplier_i`. The other operand has no effect on the decision.
- R3: The active skip number is `SKIP_LOOSE` while `aged_o` = 0 and `SKIP_STRICT` while `aged_o` = 1. Elaboration requires `SKIP_STRICT` > `SKIP_LOOSE`.
- R4: Operations are grouped into windows of `WINDOW` consecutive `op_valid_i` cycles. Each cycle with `timing_err_i` = 1 counts one error. The count is cleared after the operation that closes a window, and an error raised in that closing cycle still counts toward the closing window. `aged_o` rises on the clock edge at which a window's count would exceed `ERR_LIMIT`.
- R5: The decision is registered. After an edge that samples `op_valid_i` = 1, `decide_valid_o` = 1 and `one_cycle_o` gives that operation's class. After an edge that samples `op_valid_i` = 0, `decide_valid_o` = 0 and `one_cycle_o` keeps its previous value.
- R6: Once `aged_o` is 1 it stays 1 until reset, whatever errors or windows follow.
- R7: Synchronous active-high reset clears `one_cycle_o`, `decide_valid_o` and `aged_o` to 0 and restarts the window and error counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid_i | input | 1 | A multiplication is presented this cycle |
| mcand_i | input | OP_W | Multiplicand operand |
| mplier_i | input | OP_W | Multiplier operand |
| timing_err_i | input | 1 | Timing-error flag from the result registers |
| one_cycle_o | output | 1 | Registered class: 1 = one cycle, 0 = two cycles |
| decide_valid_o | output | 1 | Registered: `one_cycle_o` belongs to an operation sampled at the last edge |
| aged_o | output | 1 | Aging flag; 1 selects the stricter skip number |

## Verification
On every cycle the assertions check several things. `decide_valid_o` must track the previous cycle's strobe. `one_cycle_o` must hold still across idle cycles. An operand clearly below or above both thresholds must come out two-cycle or one-cycle. The aged flag must never drop, and it may only rise right after an error. The window counters must stay in range. The bench scenarios are needed for the rest. Only they show that the threshold really moves from the loose value to the strict value at the boundary counts. They also show that errors split across two windows do not add up. Finally, they show which operand each bypass configuration judges and that the other one is ignored.

// File: rtl/lat_pkg.sv
package lat_pkg;
  typedef enum logic {
    LAT_TWO = 1'b0,
    LAT_ONE = 1'b1
  } lat_e;

  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/zero_tally.sv
module zero_tally #(
  parameter int OP_W  = 16,
  parameter int CNT_W = lat_pkg::cnt_width(OP_W)
) (
  input  logic [OP_W-1:0]  word_i,
  output logic [CNT_W-1:0] zeros_o
);
  localparam int LEVELS = (OP_W < 2) ? 0 : $clog2(OP_W);
  localparam int LEAVES = 1 << LEVELS;
  localparam int NODES  = 2 * LEAVES - 1;

  logic [CNT_W-1:0] node [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < OP_W) begin : g_real
      assign node[LEAVES-1+i] = CNT_W'(~word_i[i]);
    end else begin : g_pad
      assign node[LEAVES-1+i] = '0;
    end
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_sum
    assign node[k] = node[2*k+1] + node[2*k+2];
  end

  assign zeros_o = node[0];
endmodule

// File: rtl/skip_judge.sv
module skip_judge #(
  parameter int CNT_W = 5,
  parameter int SKIP  = 7
) (
  input  logic [CNT_W-1:0] zeros_i,
  output logic             fast_o
);
  assign fast_o = (zeros_i >= CNT_W'(SKIP));
endmodule

// File: rtl/age_watch.sv
module age_watch #(
  parameter int WINDOW    = 256,
  parameter int ERR_LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic op_valid_i,
  input  logic err_i,
  output logic aged_o
);
  localparam int OPC_W = (WINDOW < 2) ? 1 : $clog2(WINDOW);
  localparam int ERC_W = $clog2(ERR_LIMIT + 2);

  logic [OPC_W-1:0] op_cnt;
  logic [ERC_W-1:0] err_cnt;
  logic             aged_q;
  logic             win_last;
  logic             over;

  assign win_last = op_valid_i && (op_cnt == OPC_W'(WINDOW - 1));
  assign over     = err_i && (err_cnt >= ERC_W'(ERR_LIMIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      op_cnt  <= '0;
      err_cnt <= '0;
      aged_q  <= 1'b0;
    end else begin
      if (win_last) op_cnt <= '0;
      else if (op_valid_i) op_cnt <= op_cnt + 1'b1;

      if (win_last) err_cnt <= '0;
      else if (err_i && err_cnt <= ERC_W'(ERR_LIMIT)) err_cnt <= err_cnt + 1'b1;

      if (over) aged_q <= 1'b1;
    end
  end

  assign aged_o = aged_q;

  AST_AGED_STICKY: assert property (@(posedge clk) disable iff (rst)
    aged_q |=> aged_q); // R6
  AST_AGED_NEEDS_ERR: assert property (@(posedge clk) disable iff (rst)
    $rose(aged_q) |-> $past(err_i)); // R4
  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    (op_cnt <= OPC_W'(WINDOW - 1)) && (err_cnt <= ERC_W'(ERR_LIMIT + 1))); // R4
endmodule

// File: rtl/adaptive_hold.sv
module adaptive_hold #(
  parameter int OP_W        = 16,
  parameter int SKIP_LOOSE  = 7,
  parameter int SKIP_STRICT = 8,
  parameter int WINDOW      = 256,
  parameter int ERR_LIMIT   = 8,
  parameter bit ROW_MODE    = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid_i,
  input  logic [OP_W-1:0] mcand_i,
  input  logic [OP_W-1:0] mplier_i,
  input  logic            timing_err_i,
  output logic            one_cycle_o,
  output logic            decide_valid_o,
  output logic            aged_o
);
  import lat_pkg::*;

  localparam int CNT_W = cnt_width(OP_W);
  localparam int SKIPS [2] = '{SKIP_LOOSE, SKIP_STRICT};

  initial begin
    AST_SKIP_ORDER: assert (SKIP_STRICT > SKIP_LOOSE); // R3
  end

  logic [OP_W-1:0]  judged;
  logic [CNT_W-1:0] zeros;
  logic [1:0]       fast;
  logic             aged;
  lat_e             verdict;
  lat_e             class_q;
  logic             vld_q;

  assign judged = ROW_MODE ? mplier_i : mcand_i;

  zero_tally #(.OP_W(OP_W), .CNT_W(CNT_W)) u_tally (
    .word_i  (judged),
    .zeros_o (zeros)
  );

  for (genvar j = 0; j < 2; j++) begin : g_judge
    skip_judge #(.CNT_W(CNT_W), .SKIP(SKIPS[j])) u_judge (
      .zeros_i (zeros),
      .fast_o  (fast[j])
    );
  end

  age_watch #(.WINDOW(WINDOW), .ERR_LIMIT(ERR_LIMIT)) u_age (
    .clk        (clk),
    .rst        (rst),
    .op_valid_i (op_valid_i),
    .err_i      (timing_err_i),
    .aged_o     (aged)
  );

  assign verdict = (aged ? fast[1] : fast[0]) ? LAT_ONE : LAT_TWO;

  always_ff @(posedge clk) begin
    if (rst) begin
      class_q <= LAT_TWO;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= op_valid_i;
      if (op_valid_i) class_q <= verdict;
    end
  end

  assign one_cycle_o    = (class_q == LAT_ONE);
  assign decide_valid_o = vld_q;
  assign aged_o         = aged;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    op_valid_i |=> decide_valid_o); // R5
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !op_valid_i |=> !decide_valid_o); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !op_valid_i |=> $stable(one_cycle_o)); // R5
  AST_FEW_ZEROS_SLOW: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && zeros < CNT_W'(SKIP_LOOSE)) |=> !one_cycle_o); // R1
  AST_MANY_ZEROS_FAST: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && zeros >= CNT_W'(SKIP_STRICT)) |=> one_cycle_o); // R1
endmodule

// File: tb/adaptive_hold_tb_top.sv
module adaptive_hold_tb_top;
  localparam int OP_W = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            op_valid = 1'b0;
  logic [OP_W-1:0] mcand = '0;
  logic [OP_W-1:0] mplier = '0;
  logic            terr = 1'b0;
  logic            one_c, dval, aged;
  logic            one_r, dval_r, aged_r;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  adaptive_hold #(.OP_W(OP_W), .SKIP_LOOSE(7), .SKIP_STRICT(8),
                  .WINDOW(8), .ERR_LIMIT(2), .ROW_MODE(1'b0)) dut_i (
    .clk(clk), .rst(rst), .op_valid_i(op_valid), .mcand_i(mcand),
    .mplier_i(mplier), .timing_err_i(terr), .one_cycle_o(one_c),
    .decide_valid_o(dval), .aged_o(aged)
  );

  adaptive_hold #(.OP_W(OP_W), .SKIP_LOOSE(7), .SKIP_STRICT(8),
                  .WINDOW(8), .ERR_LIMIT(2), .ROW_MODE(1'b1)) dut_row_i (
    .clk(clk), .rst(rst), .op_valid_i(op_valid), .mcand_i(mcand),
    .mplier_i(mplier), .timing_err_i(terr), .one_cycle_o(one_r),
    .decide_valid_o(dval_r), .aged_o(aged_r)
  );

  // {multiplicand, multiplier, expected column-mode, expected row-mode}
  localparam logic [33:0] VEC [8] = '{
    {16'hFFC0, 16'hFFFF, 1'b0, 1'b0},
    {16'hFF80, 16'h0000, 1'b1, 1'b1},
    {16'hFF00, 16'hFFC0, 1'b1, 1'b0},
    {16'h0000, 16'hFF80, 1'b1, 1'b1},
    {16'hFFFF, 16'hFF00, 1'b0, 1'b1},
    {16'hAAAA, 16'hFEFE, 1'b1, 1'b0},
    {16'hFEFE, 16'hAAAA, 1'b0, 1'b1},
    {16'h0001, 16'h7FFF, 1'b1, 1'b0}
  };

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic op(input logic [OP_W-1:0] mc, input logic [OP_W-1:0] mp, input logic e);
    @(negedge clk);
    op_valid = 1'b1; mcand = mc; mplier = mp; terr = e;
    @(posedge clk); #1;
  endtask

  task automatic idle(input logic [OP_W-1:0] mc);
    @(negedge clk);
    op_valid = 1'b0; mcand = mc; mplier = mc; terr = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; op_valid = 1'b0; terr = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // R7: reset state
    repeat (2) @(posedge clk); #1;
    chk(one_c, 1'b0, "R7 one_cycle after reset");
    chk(dval, 1'b0, "R7 valid after reset");
    chk(aged, 1'b0, "R7 aged after reset");
    @(negedge clk); rst = 1'b0;

    // R1 R2: table of operand patterns, loose threshold, both configurations
    foreach (VEC[i]) begin
      op(VEC[i][33:18], VEC[i][17:2], 1'b0);
      chk(one_c, VEC[i][1], $sformatf("R1 R2 column vec %0d", i));
      chk(one_r, VEC[i][0], $sformatf("R2 row vec %0d", i));
      chk(dval, 1'b1, "R5 valid after op");
    end

    // R5: idle cycle holds class, drops valid (last op was one-cycle)
    idle(16'hFFFF);
    chk(dval, 1'b0, "R5 valid idle");
    chk(one_c, 1'b1, "R5 hold idle");
    chk(aged, 1'b0, "R3 still fresh");

    // R4: errors split over two windows do not add up
    do_reset();
    op(16'hFFFF, 16'hFFFF, 1'b1);
    op(16'hFFFF, 16'hFFFF, 1'b1);
    for (int k = 0; k < 6; k++) op(16'hFFFF, 16'hFFFF, 1'b0);
    chk(aged, 1'b0, "R4 two errors in window");
    op(16'hFFFF, 16'hFFFF, 1'b1);
    op(16'hFFFF, 16'hFFFF, 1'b1);
    chk(aged, 1'b0, "R4 count cleared at window end");
    op(16'hFF80, 16'hFFFF, 1'b1);
    chk(aged, 1'b1, "R4 third error in window");
    chk(one_c, 1'b1, "R3 op judged with loose before flag");

    // R3: strict threshold in effect
    op(16'hFF80, 16'hFFFF, 1'b0);
    chk(one_c, 1'b0, "R3 seven zeros now two-cycle");
    op(16'hFF00, 16'hFFFF, 1'b0);
    chk(one_c, 1'b1, "R3 eight zeros still one-cycle");

    // R6: sticky across later windows
    for (int k = 0; k < 20; k++) op(16'hFFFF, 16'hFFFF, 1'b0);
    chk(aged, 1'b1, "R6 flag persists");

    // R7: reset clears flag, loose threshold returns
    do_reset();
    #1;
    chk(aged, 1'b0, "R7 reset clears aged");
    op(16'hFF80, 16'hFFFF, 1'b0);
    chk(one_c, 1'b1, "R3 loose after reset");

    finish_run();
  end
endmodule